// File: doc/BRIEF.md
# Per-Pixel Channel Padding Transform

This block sits in front of a dot-product array. Each input beat is a wide bus that carries several whole pixels in height-width-channel raster order, so every pixel's channel bytes are adjacent. The beat is cut into fixed pixel lanes, and every lane runs the same conversion. The conversion turns each unsigned 8-bit channel value into half precision (FP16). When a configuration bit is set, it first adds a signed per-channel offset and then multiplies by a per-channel power of two. The result is zero-extended to a fixed vector width for the array.

A per-lane mask marks which lanes of a beat carry real pixels. Lane vectors leave one per transfer on a valid/ready stream, lowest lane first. The input beat is held until its last marked lane has gone out. The block keeps nothing from one beat to the next. It never joins pixels across beats and never folds spatial positions into channels, so the channel count per pixel is capped at the vector width.

Top module: `pix_pad_xform`

## Requirements
- R1: After reset, with in_valid low, out_valid is 0 and in_ready is 1.
- R2: Lane k of in_data occupies bits [k*CH*8 +: CH*8]. Channel c of that lane is the byte at bit offset c*8 within the lane.
- R3: With cfg_norm_en at 0, element c of out_vec (bits [c*16 +: 16]) for c < CH is the exact FP16 encoding of channel c's unsigned byte, and cfg_bias and cfg_shift have no effect.
- R4: Elements CH to CVEC-1 of every emitted vector are 0x0000.
- R5: With cfg_norm_en at 1, element c equals (byte + bias_c) * 2^shift_c, encoded exactly in FP16. Here bias_c is the signed 9-bit field cfg_bias[c*9 +: 9] and shift_c is the signed 4-bit field cfg_shift[c*4 +: 4]. A zero result is encoded as 0x0000.
- R6: Lanes whose in_lane_mask bit is 1 are emitted one per output transfer, in increasing lane index.
- R7: Lanes whose mask bit is 0 are never emitted. A beat whose mask is all zero is accepted in one cycle with out_valid at 0.
- R8: in_ready stays 0 while more than one marked lane of the current beat remains. It is 1 in the cycle in which the last remaining lane is transferred.
- R9: While out_valid is 1 and out_ready is 0, out_vec and out_valid hold their values into the next cycle.
- R10: out_valid is 1 only while in_valid is 1, because no pixel data is kept after its beat has been accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Input beat accepted when high together with in_valid |
| in_data | input | LANES*CH*8 | Whole pixels, lane 0 in the low bits |
| in_lane_mask | input | LANES | One bit per lane, 1 = real pixel |
| cfg_norm_en | input | 1 | Enables offset and power-of-two scaling |
| cfg_bias | input | CH*9 | Signed per-channel offsets |
| cfg_shift | input | CH*4 | Signed per-channel exponent adjustments |
| out_valid | output | 1 | Output vector valid |
| out_ready | input | 1 | Downstream accepts the vector |
| out_vec | output | CVEC*16 | FP16 feature vector, element 0 in the low bits |

## Verification
The hold assertion on the output relies on the upstream stream rule: while in_valid is high and in_ready is low, in_data, in_lane_mask and the configuration inputs stay unchanged. The output vector is a function of the held beat, so it can only stay stable under backpressure if that rule is followed. The bench changes inputs only on falling edges. It changes them only after the beat was accepted or while in_valid is low, and it drives the configuration only between beats. The offsets and shifts it uses keep every result inside the range where FP16 is exact, which is the range the conversion assertions assume.

// File: rtl/pix_pad_xform.sv
module pix_pad_xform #(
  parameter int LANES = 4,
  parameter int CH    = 3,
  parameter int CVEC  = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  in_valid,
  output logic                  in_ready,
  input  logic [LANES*CH*8-1:0] in_data,
  input  logic [LANES-1:0]      in_lane_mask,
  input  logic                  cfg_norm_en,
  input  logic [CH*9-1:0]       cfg_bias,
  input  logic [CH*4-1:0]       cfg_shift,
  output logic                  out_valid,
  input  logic                  out_ready,
  output logic [CVEC*16-1:0]    out_vec
);
  localparam int PIX_W = CH * 8;
  localparam int VEC_W = CVEC * 16;

  function automatic logic [15:0] to_half(input logic [7:0] x, input logic signed [8:0] b,
                                          input logic signed [3:0] s, input logic en);
    logic signed [10:0] v;
    logic [10:0] mag;
    logic [20:0] t;
    int p, e;
    v   = en ? $signed({3'b000, x}) + 11'(b) : $signed({3'b000, x});
    mag = v[10] ? 11'(-v) : 11'(v);
    p   = 0;
    for (int i = 0; i < 11; i++) if (mag[i]) p = i;
    e   = 15 + p + (en ? int'(s) : 0);
    t   = 21'(mag) << (10 - p);
    return (mag == '0) ? 16'h0000 : {v[10], 5'(e), t[9:0]};
  endfunction

  logic [LANES-1:0] done_q, pend, sel;
  logic             last;
  logic [VEC_W-1:0] lane_vec [LANES];

  genvar k, c;
  generate
    for (k = 0; k < LANES; k++) begin : g_lane
      for (c = 0; c < CVEC; c++) begin : g_el
        if (c < CH) begin : g_conv
          assign lane_vec[k][c*16 +: 16] = to_half(in_data[k*PIX_W + c*8 +: 8],
                                                   cfg_bias[c*9 +: 9], cfg_shift[c*4 +: 4],
                                                   cfg_norm_en);
        end else begin : g_pad
          assign lane_vec[k][c*16 +: 16] = 16'h0000;
        end
      end
    end
  endgenerate

  assign pend      = {LANES{in_valid}} & in_lane_mask & ~done_q;
  assign sel       = pend & (~pend + 1'b1);
  assign last      = (pend & ~sel) == '0;
  assign out_valid = |pend;
  assign in_ready  = last && (!out_valid || out_ready);

  always_comb begin
    out_vec = '0;
    for (int i = 0; i < LANES; i++) if (sel[i]) out_vec = lane_vec[i];
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                     done_q <= '0;
    else if (in_valid && in_ready)  done_q <= '0;
    else if (out_valid && out_ready) done_q <= done_q | sel;
  end

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_vec))); // R9
  AST_PAD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_vec[VEC_W-1:CH*16] == '0)); // R4
  AST_NO_STALE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> in_valid); // R10
  AST_EMPTY_SKIP: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_lane_mask == '0) |-> (in_ready && !out_valid)); // R7
  AST_RETIRE_WITH_XFER: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && |in_lane_mask) |-> (out_valid && out_ready)); // R8
endmodule

// File: tb/tb_pix_pad_xform.sv
module tb_pix_pad_xform;
  localparam int LANES = 4, CH = 3, CVEC = 8;

  logic clk = 0, rst_n = 0;
  logic in_valid = 0, in_ready, cfg_norm_en = 0, out_valid, out_ready = 0;
  logic [LANES*CH*8-1:0] in_data = '0;
  logic [LANES-1:0] in_lane_mask = '0;
  logic [CH*9-1:0] cfg_bias = '0;
  logic [CH*4-1:0] cfg_shift = '0;
  logic [CVEC*16-1:0] out_vec;
  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  pix_pad_xform #(.LANES(LANES), .CH(CH), .CVEC(CVEC)) dut (.*);

  // {byte, bias, shift, enable, expected FP16}
  localparam int NT = 11;
  localparam logic [37:0] TBL [NT] = '{
    {8'd0,   9'h000, 4'h0, 1'b0, 16'h0000},
    {8'd1,   9'h000, 4'h0, 1'b0, 16'h3C00},
    {8'd128, 9'h000, 4'h0, 1'b0, 16'h5800},
    {8'd255, 9'h000, 4'h0, 1'b0, 16'h5BF8},
    {8'd100, 9'h005, 4'h3, 1'b0, 16'h5640},
    {8'd100, 9'h19C, 4'h0, 1'b1, 16'h0000},
    {8'd10,  9'h1EC, 4'h0, 1'b1, 16'hC900},
    {8'd255, 9'h0FF, 4'h7, 1'b1, 16'h7BF8},
    {8'd1,   9'h000, 4'h8, 1'b1, 16'h1C00},
    {8'd0,   9'h100, 4'h0, 1'b1, 16'hDC00},
    {8'd3,   9'h000, 4'h1, 1'b1, 16'h4600}
  };

  function automatic logic [15:0] ref_h(input int n);
    int a, p;
    a = (n < 0) ? -n : n;
    if (a == 0) return 16'h0000;
    p = 0;
    while ((1 << (p + 1)) <= a) p++;
    return {n < 0, 5'(15 + p), 10'((a - (1 << p)) << (10 - p))};
  endfunction

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [127:0] pad_vec(input logic [15:0] e0, e1, e2);
    return {80'h0, e2, e1, e0};
  endfunction

  task automatic summary;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual hung expected done");
      summary();
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1; #1;
    chk("R1 out_valid", 128'(out_valid), 128'(0));
    chk("R1 in_ready", 128'(in_ready), 128'(1));

    // Table walk: lane 0 channel 0, checks R3 R5 R4
    out_ready = 1;
    for (int i = 0; i < NT; i++) begin
      @(negedge clk);
      in_data = '0; in_data[7:0] = TBL[i][37:30];
      cfg_bias = '0; cfg_bias[8:0] = TBL[i][29:21];
      cfg_shift = '0; cfg_shift[3:0] = TBL[i][20:17];
      cfg_norm_en = TBL[i][16];
      in_lane_mask = 4'b0001; in_valid = 1; #1;
      chk(TBL[i][16] ? "R5 table" : "R3 table", 128'(out_vec[15:0]), 128'(TBL[i][15:0]));
      chk("R4 pad", 128'(out_vec[127:48]), 128'(0));
      chk("R8 single lane ready", 128'(in_ready), 128'(1));
      @(posedge clk);
    end
    @(negedge clk); in_valid = 0; cfg_norm_en = 0; cfg_bias = '0; cfg_shift = '0;

    // Multi-lane ordering with a hole (R2 R3 R6 R8)
    @(negedge clk);
    for (int k = 0; k < LANES; k++)
      for (int c = 0; c < CH; c++) in_data[k*24 + c*8 +: 8] = 8'(k*40 + c*7 + 1);
    cfg_bias = {9'h004, 9'h1FD, 9'h000};
    cfg_shift = {4'hF, 4'h1, 4'h0};
    in_lane_mask = 4'b1011; in_valid = 1; #1;
    chk("R2 R6 lane0", out_vec, pad_vec(ref_h(1), ref_h(8), ref_h(15)));
    chk("R8 hold lane0", 128'(in_ready), 128'(0));
    @(negedge clk); #1;
    chk("R6 lane1", out_vec, pad_vec(ref_h(41), ref_h(48), ref_h(55)));
    chk("R8 hold lane1", 128'(in_ready), 128'(0));
    // Backpressure (R9)
    out_ready = 0;
    @(negedge clk); #1;
    chk("R9 valid held", 128'(out_valid), 128'(1));
    chk("R9 vec held", out_vec, pad_vec(ref_h(41), ref_h(48), ref_h(55)));
    chk("R8 blocked", 128'(in_ready), 128'(0));
    out_ready = 1;
    @(negedge clk); #1;
    chk("R7 R6 lane3 after skip", out_vec, pad_vec(ref_h(121), ref_h(128), ref_h(135)));
    chk("R8 last lane ready", 128'(in_ready), 128'(1));
    @(negedge clk); in_valid = 0; #1;
    chk("R10 no output after beat", 128'(out_valid), 128'(0));

    // Enabled per-channel fields, lane 2 only (R5 R2)
    @(negedge clk);
    in_data[2*24 +: 24] = {8'd30, 8'd20, 8'd10};
    cfg_norm_en = 1; in_lane_mask = 4'b0100; in_valid = 1; #1;
    chk("R5 per channel", out_vec, pad_vec(ref_h(10), ref_h(34), ref_h(17)));
    @(negedge clk); in_valid = 0; cfg_norm_en = 0;

    // Empty mask (R7)
    @(negedge clk); in_lane_mask = 4'b0000; in_valid = 1; #1;
    chk("R7 empty out_valid", 128'(out_valid), 128'(0));
    chk("R7 empty in_ready", 128'(in_ready), 128'(1));
    @(negedge clk); in_valid = 0; in_lane_mask = 4'b1111; #1;
    chk("R10 mask without valid", 128'(out_valid), 128'(0));

    // Reset in mid-beat then restart (R1)
    @(negedge clk); in_lane_mask = 4'b0011; in_valid = 1;
    @(negedge clk); in_valid = 0; rst_n = 0;
    @(negedge clk); rst_n = 1; #1;
    chk("R1 after reset", 128'({out_valid, in_ready}), 128'(2'b01));

    finished = 1;
    summary();
  end
endmodule